// File: doc/BRIEF.md
# Sixteen-bit single-cycle processor core

`tiny16_core` is a single-cycle processor for a small 16-bit load/store instruction set with eight opcodes. Each clock it fetches one word from an internal instruction array, decodes it, reads up to two of its eight registers, and computes the result in an adder/NAND unit. It then writes a register or a word of its internal data array and chooses the next program counter. All addresses count 16-bit words.

A host fills both arrays through a single write port, usually while reset is held, and then releases reset. Execution begins at address 0 and runs until the core decodes the halt encoding. The core then raises `halted_o` and freezes. A combinational debug port returns any register's value, so results can be read out after the program stops.

Top module: `tiny16_core`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the PC is 0, every register reads 0 and `halted_o` is 0.
- R2: Register 0 always reads 0 on the debug port. An instruction that targets register 0 leaves it at 0.
- R3: Opcode in bits 15:13 (add 000, addi 001, nand 010, lui 011, lw 100, sw 101, beq 110, jalr 111). regA is bits 12:10, regB bits 9:7, regC bits 2:0. The signed 7-bit immediate is bits 6:0. The lui immediate is bits 9:0.
- R4: add writes regB+regC (modulo 2^16) to regA. nand writes ~(regB & regC) to regA.
- R5: addi writes regB plus the sign-extended 7-bit immediate to regA, covering -64 through 63.
- R6: lui writes its 10-bit immediate to bits 15:6 of regA and zeros to bits 5:0.
- R7: lw loads regA from data word regB+simm7. sw stores regA to that word. Only the low DMEM_AW address bits select the word.
- R8: beq with regA equal to regB sets the PC to PC+1+simm7, which permits backward targets. Otherwise the PC becomes PC+1.
- R9: jalr with a zero immediate writes PC+1 to regA and jumps to the value regB held before the write, even when regA equals regB.
- R10: jalr with regA=0, regB=0 and a non-zero immediate halts. `halted_o` rises and stays high, and the PC, registers and data array hold until reset.
- R11: Any other jalr with a non-zero immediate writes no register and advances the PC by 1.
- R12: With `load_en_i` high, `load_data_i` is written to word `load_addr_i` of the instruction array (`load_sel_i`=0) or the data array (`load_sel_i`=1). This works during reset too. No instruction executes in that cycle.
- R13: Outside reset, halt and load cycles, exactly one instruction completes per clock. Non-control instructions advance the PC by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Array write strobe; stalls execution |
| load_sel_i | input | 1 | 0 selects instruction array, 1 data array |
| load_addr_i | input | LOAD_AW | Word address of the array write |
| load_data_i | input | 16 | Word to write |
| dbg_addr_i | input | 3 | Register index for debug read |
| dbg_data_o | output | 16 | Value of the selected register |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The checker assumes the instruction array changes only through the load port. Because every load cycle also stalls the core, the fetched word cannot change under an instruction that is executing. It also assumes every program ends in the halt encoding. Each bench scenario writes its program and data while reset is low. One scenario also loads while the core is running, to observe the stall. Every program ends in a halt word, and jump targets always land on defined words, so execution never reaches stale array contents.

// File: rtl/tiny16_pkg.sv
package tiny16_pkg;
  localparam int unsigned XLEN = 16;
  localparam int unsigned NREG = 8;
  localparam int unsigned RIDX = $clog2(NREG);

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADDI = 3'b001,
    OP_NAND = 3'b010,
    OP_LUI  = 3'b011,
    OP_LW   = 3'b100,
    OP_SW   = 3'b101,
    OP_BEQ  = 3'b110,
    OP_JALR = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_NAND, ALU_PASSB} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    alu_op_e alu_op;
    logic    use_imm;
    logic    mem_we;
    logic    is_beq;
    logic    is_jump;
    logic    is_halt;
  } ctrl_t;
endpackage

// File: rtl/tiny16_decode.sv
module tiny16_decode
  import tiny16_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctrl_t           ctrl_o,
  output logic [RIDX-1:0] wr_addr_o,
  output logic [RIDX-1:0] rd1_addr_o,
  output logic [RIDX-1:0] rd2_addr_o,
  output logic [XLEN-1:0] imm_o
);
  opcode_e         op;
  logic [RIDX-1:0] fa, fb, fc;
  logic [6:0]      simm;

  assign op   = opcode_e'(instr_i[15:13]);
  assign fa   = instr_i[12:10];
  assign fb   = instr_i[9:7];
  assign fc   = instr_i[2:0];
  assign simm = instr_i[6:0];

  assign wr_addr_o  = fa;
  assign rd1_addr_o = fb;
  // second port: regC for register-register ops, regA otherwise (store data, compare)
  assign rd2_addr_o = (op == OP_ADD || op == OP_NAND) ? fc : fa;
  assign imm_o      = (op == OP_LUI) ? {instr_i[9:0], 6'b0} : {{(XLEN-7){simm[6]}}, simm};

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_ADD:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
      OP_ADDI: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_ADD; ctrl_o.use_imm = 1'b1; end
      OP_NAND: begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_NAND; end
      OP_LUI:  begin ctrl_o.rf_we = 1'b1; ctrl_o.alu_op = ALU_PASSB; ctrl_o.use_imm = 1'b1; end
      OP_LW:   begin
        ctrl_o.rf_we = 1'b1; ctrl_o.wb_sel = WB_MEM; ctrl_o.use_imm = 1'b1;
      end
      OP_SW:   begin ctrl_o.mem_we = 1'b1; ctrl_o.use_imm = 1'b1; end
      OP_BEQ:  ctrl_o.is_beq = 1'b1;
      OP_JALR: begin
        if (simm == 7'd0) begin
          ctrl_o.rf_we   = 1'b1;
          ctrl_o.wb_sel  = WB_LINK;
          ctrl_o.is_jump = 1'b1;
        end else if (fa == '0 && fb == '0) begin
          ctrl_o.is_halt = 1'b1;
        end
        // other non-zero immediates: system call, no effect beyond PC+1
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/tiny16_regfile.sv
module tiny16_regfile
  import tiny16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RIDX-1:0] waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RIDX-1:0] raddr1_i,
  output logic [XLEN-1:0] rdata1_o,
  input  logic [RIDX-1:0] raddr2_i,
  output logic [XLEN-1:0] rdata2_o,
  input  logic [RIDX-1:0] dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  function automatic logic [XLEN-1:0] rd(input logic [RIDX-1:0] a);
    return (a == '0) ? '0 : regs_q[a];
  endfunction

  assign rdata1_o   = rd(raddr1_i);
  assign rdata2_o   = rd(raddr2_i);
  assign dbg_data_o = rd(dbg_addr_i);
endmodule

// File: rtl/tiny16_alu.sv
module tiny16_alu
  import tiny16_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_NAND:  y_o = ~(a_i & b_i);
      ALU_PASSB: y_o = b_i;
      default:   y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/tiny16_core.sv
module tiny16_core
  import tiny16_pkg::*;
#(
  parameter  int unsigned IMEM_AW = 8,
  parameter  int unsigned DMEM_AW = 8,
  localparam int unsigned LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic               load_sel_i,
  input  logic [LOAD_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]    load_data_i,
  input  logic [RIDX-1:0]    dbg_addr_i,
  output logic [XLEN-1:0]    dbg_data_o,
  output logic               halted_o
);
  localparam int unsigned IMEM_DEPTH = 1 << IMEM_AW;
  localparam int unsigned DMEM_DEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] dmem [DMEM_DEPTH];

  logic [XLEN-1:0] pc_q, pc_plus1, next_pc, instr;
  logic            halted_q, exec_en;
  ctrl_t           ctrl;
  logic [RIDX-1:0] wr_addr, rd1_addr, rd2_addr;
  logic [XLEN-1:0] imm, rd1, rd2, alu_b, alu_y, wdata, mem_rdata;
  logic            rf_we, mem_we;

  assign exec_en  = !halted_q && !load_en_i;
  assign instr    = imem[pc_q[IMEM_AW-1:0]];
  assign pc_plus1 = pc_q + 1'b1;

  tiny16_decode u_dec (
    .instr_i   (instr),
    .ctrl_o    (ctrl),
    .wr_addr_o (wr_addr),
    .rd1_addr_o(rd1_addr),
    .rd2_addr_o(rd2_addr),
    .imm_o     (imm)
  );

  assign rf_we  = exec_en && ctrl.rf_we;
  assign mem_we = exec_en && ctrl.mem_we;

  tiny16_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (wr_addr),
    .wdata_i   (wdata),
    .raddr1_i  (rd1_addr),
    .rdata1_o  (rd1),
    .raddr2_i  (rd2_addr),
    .rdata2_o  (rd2),
    .dbg_addr_i(dbg_addr_i),
    .dbg_data_o(dbg_data_o)
  );

  assign alu_b = ctrl.use_imm ? imm : rd2;

  tiny16_alu u_alu (
    .op_i(ctrl.alu_op),
    .a_i (rd1),
    .b_i (alu_b),
    .y_o (alu_y)
  );

  assign mem_rdata = dmem[alu_y[DMEM_AW-1:0]];

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wdata = mem_rdata;
      WB_LINK: wdata = pc_plus1;
      default: wdata = alu_y;
    endcase
  end

  always_comb begin
    if (ctrl.is_jump)                  next_pc = rd1;
    else if (ctrl.is_beq && rd1 == rd2) next_pc = pc_plus1 + imm;
    else                               next_pc = pc_plus1;
  end

  // halt leaves the PC on the halt word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (exec_en) begin
      if (ctrl.is_halt) halted_q <= 1'b1;
      else              pc_q     <= next_pc;
    end
  end

  // arrays are not reset so they can be filled while reset is held
  always_ff @(posedge clk_i) begin
    if (load_en_i) begin
      if (load_sel_i) dmem[load_addr_i[DMEM_AW-1:0]] <= load_data_i;
      else            imem[load_addr_i[IMEM_AW-1:0]] <= load_data_i;
    end else if (mem_we) begin
      dmem[alu_y[DMEM_AW-1:0]] <= rd2;
    end
  end

  assign halted_o = halted_q;
endmodule

// File: rtl/tiny16_core_chk.sv
module tiny16_core_chk
  import tiny16_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            load_en_i,
  input logic [RIDX-1:0] dbg_addr_i,
  input logic [XLEN-1:0] dbg_data_o,
  input logic            halted_o,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            rf_we_i,
  input logic            mem_we_i
);
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o); // R10
  AST_HALT_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pc_i)); // R10
  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!rf_we_i && !mem_we_i)); // R10
  AST_LOAD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> $stable(pc_i)); // R12
  AST_REG0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == '0) |-> (dbg_data_o == '0)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !load_en_i && instr_i[15:14] != 2'b11)
      |=> (pc_i == XLEN'($past(pc_i) + 1'b1))); // R13
  AST_SYSCALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:13] == 3'b111 && instr_i[6:0] != 7'd0) |-> !rf_we_i); // R11
endmodule

bind tiny16_core tiny16_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_i (load_en_i),
  .dbg_addr_i(dbg_addr_i),
  .dbg_data_o(dbg_data_o),
  .halted_o  (halted_o),
  .pc_i      (pc_q),
  .instr_i   (instr),
  .rf_we_i   (rf_we),
  .mem_we_i  (mem_we)
);

// File: tb/sim_tiny16_core.sv
module sim_tiny16_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en = 1'b0;
  logic        load_sel = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [2:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  logic        halted;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny16_core u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .load_en_i  (load_en),
    .load_sel_i (load_sel),
    .load_addr_i(load_addr),
    .load_data_i(load_data),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data),
    .halted_o   (halted)
  );

  // R3 encodings
  function automatic logic [15:0] enc_rrr(logic [2:0] op, int a, int b, int c);
    return {op, 3'(a), 3'(b), 4'b0, 3'(c)};
  endfunction
  function automatic logic [15:0] enc_rri(logic [2:0] op, int a, int b, int imm);
    return {op, 3'(a), 3'(b), 7'(imm)};
  endfunction
  function automatic logic [15:0] enc_lui(int a, int imm);
    return {3'b011, 3'(a), 10'(imm)};
  endfunction
  localparam logic [15:0] HALT = {3'b111, 3'd0, 3'd0, 7'd1};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int idx, logic [15:0] exp);
    dbg_addr = 3'(idx);
    #1;
    check(req, dbg_data, exp);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_ni = 1'b0;
  endtask

  task automatic put(logic sel, int addr, logic [15:0] w);
    load_en = 1'b1; load_sel = sel; load_addr = 8'(addr); load_data = w;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_to_halt(string req);
    rst_ni = 1'b1;
    for (int i = 0; i < 300; i++) begin
      if (halted) break;
      @(negedge clk);
    end
    check(req, 16'(halted), 16'd1);
  endtask

  task automatic t_arith();
    begin_prog();
    put(0, 0, enc_rri(3'b001, 1, 0, 5));
    put(0, 1, enc_rri(3'b001, 2, 0, -3));
    put(0, 2, enc_rrr(3'b000, 3, 1, 2));
    put(0, 3, enc_rrr(3'b010, 4, 1, 2));
    put(0, 4, enc_rri(3'b001, 0, 0, 7));
    put(0, 5, enc_rri(3'b001, 5, 0, 63));
    put(0, 6, enc_rri(3'b001, 6, 0, -64));
    put(0, 7, enc_rrr(3'b000, 7, 5, 6));
    put(0, 8, HALT);
    run_to_halt("R10 arith halt");
    chk_reg("R5 addi +5", 1, 16'd5);
    chk_reg("R5 addi -3", 2, 16'hFFFD);
    chk_reg("R4 add", 3, 16'(5 - 3));
    chk_reg("R4 nand", 4, ~(16'd5 & 16'hFFFD));
    chk_reg("R2 r0 write ignored", 0, 16'd0);
    chk_reg("R5 addi max", 5, 16'd63);
    chk_reg("R5 addi min", 6, 16'hFFC0);
    chk_reg("R4 add wrap", 7, 16'(63 - 64));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 halted cleared", 16'(halted), 16'd0);
    chk_reg("R1 r1 cleared", 1, 16'd0);
    chk_reg("R1 r4 cleared", 4, 16'd0);
    chk_reg("R1 r7 cleared", 7, 16'd0);
  endtask

  task automatic t_lui();
    begin_prog();
    put(0, 0, enc_lui(1, 10'h3FF));
    put(0, 1, enc_lui(2, 1));
    put(0, 2, enc_rri(3'b001, 2, 2, 5));
    put(0, 3, HALT);
    run_to_halt("R10 lui halt");
    chk_reg("R6 lui all ones", 1, 16'hFFC0);
    chk_reg("R6 lui one", 2, 16'h0040 + 16'd5);
  endtask

  task automatic t_mem();
    begin_prog();
    put(1, 10, 16'h1234);
    put(0, 0, enc_rri(3'b001, 1, 0, 8));
    put(0, 1, enc_rri(3'b100, 2, 1, 2));
    put(0, 2, enc_rri(3'b001, 3, 0, -7));
    put(0, 3, enc_rri(3'b101, 3, 1, -1));
    put(0, 4, enc_rri(3'b100, 4, 0, 7));
    put(0, 5, enc_lui(5, 4));
    put(0, 6, enc_rri(3'b100, 6, 5, 10));
    put(0, 7, HALT);
    run_to_halt("R10 mem halt");
    chk_reg("R7 lw positive offset", 2, 16'h1234);
    chk_reg("R7 sw negative offset then lw", 4, 16'hFFF9);
    chk_reg("R7 address wraps to low bits", 6, 16'h1234);
  endtask

  task automatic t_branch();
    begin_prog();
    put(0, 0, enc_rri(3'b001, 1, 0, 3));
    put(0, 1, enc_rri(3'b110, 1, 0, 2));
    put(0, 2, enc_rri(3'b001, 2, 0, 1));
    put(0, 3, enc_rri(3'b110, 0, 0, 1));
    put(0, 4, enc_rri(3'b001, 3, 0, 9));
    put(0, 5, enc_rri(3'b001, 5, 0, 5));
    put(0, 6, enc_rri(3'b001, 4, 4, 1));
    put(0, 7, enc_rri(3'b001, 5, 5, -1));
    put(0, 8, enc_rri(3'b110, 5, 0, 1));
    put(0, 9, enc_rri(3'b110, 0, 0, -4));
    put(0, 10, HALT);
    run_to_halt("R10 branch halt");
    chk_reg("R8 not taken falls through", 2, 16'd1);
    chk_reg("R8 taken skips", 3, 16'd0);
    chk_reg("R8 backward loop count", 4, 16'd5);
    chk_reg("R8 loop exit", 5, 16'd0);
  endtask

  task automatic t_jump();
    begin_prog();
    put(0, 0, enc_rri(3'b001, 1, 0, 4));
    put(0, 1, enc_rri(3'b111, 2, 1, 0));
    put(0, 2, enc_rri(3'b001, 3, 0, 1));
    put(0, 3, HALT);
    put(0, 4, enc_rri(3'b001, 4, 0, 6));
    put(0, 5, enc_rri(3'b001, 5, 0, 8));
    put(0, 6, enc_rri(3'b111, 5, 5, 0));
    put(0, 7, enc_rri(3'b001, 6, 0, 1));
    put(0, 8, HALT);
    run_to_halt("R10 jump halt");
    chk_reg("R9 link value", 2, 16'd2);
    chk_reg("R9 skipped slot", 3, 16'd0);
    chk_reg("R9 target reached", 4, 16'd6);
    chk_reg("R9 same reg link", 5, 16'd7);
    chk_reg("R9 old regB target", 6, 16'd0);
  endtask

  task automatic t_syscall_halt();
    begin_prog();
    put(0, 0, enc_rri(3'b001, 2, 0, 9));
    put(0, 1, enc_rri(3'b111, 1, 2, 3));
    put(0, 2, enc_rri(3'b001, 3, 0, 1));
    put(0, 3, enc_rri(3'b111, 0, 0, 42));
    put(0, 4, enc_rri(3'b001, 7, 0, 1));
    run_to_halt("R10 halt with other immediate");
    chk_reg("R11 syscall no link", 1, 16'd0);
    chk_reg("R11 syscall falls through", 3, 16'd1);
    repeat (5) @(negedge clk);
    check("R10 halted sticky", 16'(halted), 16'd1);
    chk_reg("R10 frozen after halt", 7, 16'd0);
    chk_reg("R10 state kept", 3, 16'd1);
  endtask

  task automatic t_stall();
    begin_prog();
    put(0, 0, enc_rri(3'b001, 1, 0, 1));
    put(0, 1, enc_rri(3'b001, 1, 1, 1));
    put(0, 2, enc_rri(3'b100, 2, 0, 20));
    put(0, 3, HALT);
    load_en = 1'b1; load_sel = 1'b1; load_addr = 8'd20; load_data = 16'hABCD;
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk_reg("R12 no execution while loading", 1, 16'd0);
    load_en = 1'b0;
    @(negedge clk);
    chk_reg("R13 one instruction per clock", 1, 16'd1);
    @(negedge clk);
    chk_reg("R13 second instruction", 1, 16'd2);
    run_to_halt("R10 stall halt");
    chk_reg("R12 data written while running", 2, 16'hABCD);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_arith();
    t_reset();
    t_lui();
    t_mem();
    t_branch();
    t_jump();
    t_syscall_halt();
    t_stall();
    finish_run();
  end
endmodule